// File: doc/BRIEF.md
# Pi/4-Shifted Differential QPSK Symbol Mapper

This block turns a serial bit stream into the per-symbol I and Q impulse values of a pi/4-shifted differential QPSK transmitter. Bits arrive one per accepted handshake. They are grouped into pairs, and each pair selects an odd multiple of pi/4. That step is added to the phase of the previous symbol. The new phase is then looked up as a pair of signed fixed-point amplitudes and handed to external pulse-shaping filters.

Because every step is an odd multiple of pi/4, the symbols alternate between the axis-aligned QPSK points and the diagonal points. Over time the block visits eight absolute phases. The phase is kept as a 3-bit index in units of pi/4 that wraps modulo 8. A synchronous reset returns the phase to 0 rad and drops any half-received pair.

Top module: `dqpsk_mapper`

## Requirements
- R1: Of each pair of accepted bits, the earlier bit is X and the later bit is Y. The step code is {X,Y}, with X as the most significant bit.
- R2: The step codes map to phase steps in units of pi/4 as follows: code 00 gives +1, code 01 gives +3, code 11 gives +5 (-3pi/4), and code 10 gives +7 (-pi/4).
- R3: The new phase index is the previous index plus the step, taken modulo 8.
- R4: The outputs for phase index p are I = round(F*cos(p*pi/4)) and Q = round(F*sin(p*pi/4)), where F = 32767. Each component is therefore one of 0, +/-32767 or +/-23170, as signed 16-bit values.
- R5: Consecutive symbols alternate between the axis points (I or Q is 0) and the diagonal points. The first symbol after reset is diagonal.
- R6: `sym_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the second bit of a pair. The new I/Q values are present in that same cycle.
- R7: A lone first bit is held for any number of idle cycles until its partner is accepted.
- R8: When no pair completes, the phase does not advance and `i_out`/`q_out` keep their values.
- R9: While `rst_n` is low at a clock edge, the block sets the phase index to 0, discards any pending bit, drives `sym_valid` low and drives I = 32767, Q = 0.
- R10: `bit_ready` is high in every cycle, so a bit is accepted at every edge where `bit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` holds a bit to accept |
| bit_ready | output | 1 | Block can take a bit (always high) |
| sym_valid | output | 1 | One-cycle pulse marking a new symbol |
| i_out | output | 16 | Signed in-phase impulse amplitude |
| q_out | output | 16 | Signed quadrature impulse amplitude |

## Verification
The bench walks long symbol streams so that every step code is applied from every one of the eight phases. A swapped mapping entry or a bad wrap would place a symbol on the wrong point, and a swapped bit order would mirror the steps (+3 against +7). It feeds bits back to back and also with idle gaps inside a pair. A mapper that lost its held bit, or that advanced the phase on idle cycles, would produce a shifted or missing symbol. A reset between the two bits of a pair checks that the half-pair is discarded: a design that kept it would decode the next pair off by one bit.

// File: rtl/dqpsk_pkg.sv
// Shared types for the differential QPSK mapper.
// Assumes the phase is counted in units of pi/4, so a 3-bit index covers a full turn.
package dqpsk_pkg;
    localparam int PH_W = 3;

    // Step selector: x is the earlier bit of the pair, y the later one.
    typedef struct packed {
        logic x;
        logic y;
    } dibit_t;

    typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/dqpsk_bit_pairer.sv
// Serial-to-parallel split: collects two accepted bits into one step selector.
// Assumes a bit is accepted at every edge where bit_valid is high.
// The pair is presented combinationally on the edge that accepts the second bit.
module dqpsk_bit_pairer
    import dqpsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_in,
    input  logic   bit_valid,
    output logic   pair_valid,
    output dibit_t pair
);
    logic have_x;
    logic x_q;

    // Pair completes when a bit arrives while the first bit is already held.
    always_comb begin
        pair_valid = bit_valid && have_x;
        pair.x     = x_q;
        pair.y     = bit_in;
    end

    // Store the first bit of a pair, or release it once its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_x <= 1'b0;
            x_q    <= 1'b0;
        end else if (bit_valid) begin
            if (have_x) begin
                have_x <= 1'b0;
            end else begin
                have_x <= 1'b1;
                x_q    <= bit_in;
            end
        end
    end
endmodule

// File: rtl/dqpsk_phase_accum.sv
// Gray-coded step lookup and modulo-8 phase accumulator.
// Assumes pair_valid pulses once per completed pair. The index wraps through its natural width.
module dqpsk_phase_accum
    import dqpsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pair_valid,
    input  dibit_t pair,
    output phase_t phase_next,
    output phase_t phase_q
);
    phase_t step;

    // Map the step selector to an odd multiple of pi/4.
    always_comb begin
        unique case ({pair.x, pair.y})
            2'b00:   step = phase_t'(1);
            2'b01:   step = phase_t'(3);
            2'b11:   step = phase_t'(5);
            default: step = phase_t'(7);
        endcase
        phase_next = pair_valid ? phase_t'(phase_q + step) : phase_q;
    end

    // Hold the running phase; reset returns it to 0 rad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_next;
        end
    end
endmodule

// File: rtl/dqpsk_iq_lut.sv
// Converts a phase index into signed I/Q impulse amplitudes and registers them.
// Assumes load is high only for a new symbol. Between symbols the outputs hold.
module dqpsk_iq_lut
    import dqpsk_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FULL_SCALE = 32767,
    parameter int DIAG_SCALE = 23170
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  phase_t                     phase,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] i_out,
    output logic signed [SAMPLE_W-1:0] q_out
);
    localparam logic signed [SAMPLE_W-1:0] PF = SAMPLE_W'(FULL_SCALE);
    localparam logic signed [SAMPLE_W-1:0] PD = SAMPLE_W'(DIAG_SCALE);
    localparam logic signed [SAMPLE_W-1:0] NF = -PF;
    localparam logic signed [SAMPLE_W-1:0] ND = -PD;
    localparam logic signed [SAMPLE_W-1:0] ZZ = '0;

    logic signed [SAMPLE_W-1:0] i_nxt;
    logic signed [SAMPLE_W-1:0] q_nxt;

    // Eight-point cosine/sine table in steps of pi/4.
    always_comb begin
        unique case (phase)
            3'd0:    begin i_nxt = PF; q_nxt = ZZ; end
            3'd1:    begin i_nxt = PD; q_nxt = PD; end
            3'd2:    begin i_nxt = ZZ; q_nxt = PF; end
            3'd3:    begin i_nxt = ND; q_nxt = PD; end
            3'd4:    begin i_nxt = NF; q_nxt = ZZ; end
            3'd5:    begin i_nxt = ND; q_nxt = ND; end
            3'd6:    begin i_nxt = ZZ; q_nxt = NF; end
            default: begin i_nxt = PD; q_nxt = ND; end
        endcase
    end

    // Register a new impulse pair per symbol; reset shows the 0 rad reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            i_out     <= PF;
            q_out     <= ZZ;
        end else begin
            out_valid <= load;
            if (load) begin
                i_out <= i_nxt;
                q_out <= q_nxt;
            end
        end
    end
endmodule

// File: rtl/dqpsk_mapper.sv
// Top of the pi/4-shifted differential QPSK symbol mapper.
// Pairs serial bits, accumulates the Gray-coded phase steps and emits one I/Q impulse per symbol.
// Assumes the downstream filters always take the impulse, so there is no output back-pressure.
module dqpsk_mapper
    import dqpsk_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FULL_SCALE = 32767,
    parameter int DIAG_SCALE = 23170
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_in,
    input  logic                       bit_valid,
    output logic                       bit_ready,
    output logic                       sym_valid,
    output logic signed [SAMPLE_W-1:0] i_out,
    output logic signed [SAMPLE_W-1:0] q_out
);
    logic   pair_valid;
    dibit_t pair;
    phase_t phase_next;
    phase_t phase_q;

    // The mapper consumes one bit per cycle and never stalls its input.
    assign bit_ready = 1'b1;

    dqpsk_bit_pairer u_pairer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .pair_valid (pair_valid),
        .pair       (pair)
    );

    dqpsk_phase_accum u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_valid (pair_valid),
        .pair       (pair),
        .phase_next (phase_next),
        .phase_q    (phase_q)
    );

    dqpsk_iq_lut #(
        .SAMPLE_W   (SAMPLE_W),
        .FULL_SCALE (FULL_SCALE),
        .DIAG_SCALE (DIAG_SCALE)
    ) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pair_valid),
        .phase     (phase_next),
        .out_valid (sym_valid),
        .i_out     (i_out),
        .q_out     (q_out)
    );
endmodule

// File: rtl/dqpsk_mapper_chk.sv
// Property checker for dqpsk_mapper, attached by bind.
// Watches only the ports and keeps its own small history registers.
module dqpsk_mapper_chk #(
    parameter int SAMPLE_W   = 16,
    parameter int FULL_SCALE = 32767,
    parameter int DIAG_SCALE = 23170
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bit_in,
    input logic                       bit_valid,
    input logic                       bit_ready,
    input logic                       sym_valid,
    input logic signed [SAMPLE_W-1:0] i_out,
    input logic signed [SAMPLE_W-1:0] q_out
);
    localparam logic signed [SAMPLE_W-1:0] PF = SAMPLE_W'(FULL_SCALE);
    localparam logic signed [SAMPLE_W-1:0] PD = SAMPLE_W'(DIAG_SCALE);

    logic seen;
    logic prev_axis;
    logic axis_now;
    logic legal_pt;

    // Classify the current output point.
    always_comb begin
        axis_now = (i_out == '0) || (q_out == '0);
        legal_pt = ((i_out == PF || i_out == -PF) && q_out == '0)
                || ((q_out == PF || q_out == -PF) && i_out == '0)
                || ((i_out == PD || i_out == -PD) && (q_out == PD || q_out == -PD));
    end

    // Track history: cycles since reset and the class of the last symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            prev_axis <= 1'b1;
        end else begin
            seen <= 1'b1;
            if (sym_valid) prev_axis <= axis_now;
        end
    end

    // R4
    legal_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legal_pt);

    // R5
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (axis_now != prev_axis));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && sym_valid) |-> $past(bit_valid));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !sym_valid) |-> ($stable(i_out) && $stable(q_out)));
endmodule

bind dqpsk_mapper dqpsk_mapper_chk #(
    .SAMPLE_W   (SAMPLE_W),
    .FULL_SCALE (FULL_SCALE),
    .DIAG_SCALE (DIAG_SCALE)
) u_chk (.*);

// File: tb/test_dqpsk_mapper.sv
module test_dqpsk_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int FS = 32767;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_ready;
    logic sym_valid;
    logic signed [SW-1:0] i_out;
    logic signed [SW-1:0] q_out;

    int checks = 0;
    int failures = 0;

    // model state
    int  ph = 0;
    bit  pend = 0;
    bit  xb = 0;
    int  exp_i = FS;
    int  exp_q = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqpsk_mapper i_dqpsk_mapper (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .bit_ready(bit_ready), .sym_valid(sym_valid), .i_out(i_out), .q_out(q_out)
    );

    function automatic int rnd(real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic check(string tag, bit exp_v);
        checks++;
        if (sym_valid !== exp_v || int'(i_out) != exp_i || int'(q_out) != exp_q
            || bit_ready !== 1'b1) begin
            failures++;
            $display("FAIL %s: valid=%0b i=%0d q=%0d ready=%0b expected valid=%0b i=%0d q=%0d ready=1",
                     tag, sym_valid, i_out, q_out, bit_ready, exp_v, exp_i, exp_q);
        end
    endtask

    // Called at a negedge: present one bit, then check at the following negedge.
    task automatic issue(bit b, string tag);
        bit done;
        int step;
        bit_valid = 1'b1;
        bit_in = b;
        done = pend;
        if (pend) begin
            case ({xb, b})
                2'b00: step = 1;
                2'b01: step = 3;
                2'b11: step = 5;
                default: step = 7;
            endcase
            ph = (ph + step) % 8;
            exp_i = rnd(FS * $cos(ph * 3.14159265358979 / 4.0));
            exp_q = rnd(FS * $sin(ph * 3.14159265358979 / 4.0));
            pend = 0;
        end else begin
            pend = 1;
            xb = b;
        end
        @(negedge clk);
        check(tag, done);
    endtask

    task automatic idle(int n, string tag);
        bit_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(tag, 1'b0);
        end
    endtask

    task automatic do_reset(int n);
        bit_valid = 1'b0;
        rst_n = 1'b0;
        repeat (n) @(negedge clk);
        ph = 0; pend = 0; exp_i = FS; exp_q = 0;
        check("R9 reset state", 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // R1: bit order, 0 then 1 gives code 01 -> +3
        issue(1'b0, "R1 first bit");
        issue(1'b1, "R1 order 01 gives +3");
        // R9: reset after a lone bit discards it
        issue(1'b1, "R7 lone bit");
        do_reset(2);
        issue(1'b1, "R9 after reset");
        issue(1'b0, "R9 pair from phase 0 code 10");
        // R7/R8: gaps inside and between pairs
        issue(1'b1, "R7 held bit");
        idle(5, "R8 hold during gap");
        issue(1'b1, "R7 partner after gap code 11");
        idle(3, "R8 hold between symbols");
        // R2/R3/R4/R5: every code from every phase, back to back (R10 ready high)
        for (int s = 0; s < 128; s++) begin
            int code = (s + s / 8) % 4;
            issue(code[1], "R2 R3 step");
            issue(code[0], "R4 R5 symbol point");
        end
        // R6: pulse drops after a symbol when input idles
        idle(2, "R6 single pulse");
        // R8: irregular gaps
        for (int s = 0; s < 40; s++) begin
            issue(s[0], "R3 gapped stream");
            idle(s % 3, "R8 gapped idle");
        end
        idle(2, "R6 idle tail");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule